// File: doc/BRIEF.md
# I2C Target Protocol Engine

This block is the target (responder) side of a two-wire I2C bus. It samples the bus clock and data lines with the system clock, passes each through a short synchronizer chain, and decodes bus conditions from the synchronized levels. A START is the data line falling while the clock line is high, and a STOP is the data line rising while the clock line is high. Between these, data bits are taken while the clock is high and may change only while it is low.

After a START the engine collects one byte: a 7-bit address followed by a direction bit. If the address matches the configured target address, the engine acknowledges in the ninth clock. It then either accepts data bytes from the controller or supplies data bytes to it, with one acknowledge bit after each byte. The data line is never driven high. The single output `sdaPullEn` asks the pad to pull the line low, and releasing it leaves the line to the pull-up.

On the user side, received bytes come out through a valid/ready handshake. Bytes to be sent go through a one-entry holding buffer with its own valid/ready handshake.

Top module: `i2c_tgt_top`

## Requirements
- R1: After reset, `sdaPullEn` is 0, `rxValid` is 0 and `txReady` is 1.
- R2: SDA falling while SCL is high (START) puts the engine into address reception from any state, and any partly received byte is dropped.
- R3: SDA rising while SCL is high (STOP) returns the engine to idle. Until the next START, no clocking of the bus makes it pull SDA.
- R4: The first byte after START is taken MSB first: seven address bits, then a direction bit (1 = controller reads, 0 = controller writes). On an address match the engine pulls SDA low for the whole ninth clock.
- R5: When the address does not match, the engine does not pull SDA at any point until the next START.
- R6: In a write transfer, each 8-bit byte is taken MSB first and acknowledged in the ninth clock. It is presented on `rxData` with `rxValid` set before the ninth clock begins.
- R7: `rxValid` and `rxData` hold until `rxReady` is high at a clock edge. A write byte that completes while `rxValid` is still set is not acknowledged (SDA stays released in the ninth clock) and is discarded.
- R8: In a read transfer, each byte is sent MSB first: a 0 bit pulls SDA and a 1 bit releases it. `sdaPullEn` never changes while SCL is high.
- R9: In a read transfer, SDA low in the ninth clock (controller ACK) makes the engine send the next byte. SDA high (NACK) makes it release SDA until the next START.
- R10: The transmit buffer holds one byte. `txReady` is 1 exactly when it is empty, and a byte is taken on a clock edge with `txValid` and `txReady` both high. If the buffer is empty when a read byte begins, 8'hFF is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullEn | output | 1 | 1 pulls the data line low, 0 releases it |
| rxData | output | 8 | Last byte received from the controller |
| rxValid | output | 1 | `rxData` holds an unconsumed byte |
| rxReady | input | 1 | User takes the received byte |
| txData | input | 8 | Byte offered for the next read |
| txValid | input | 1 | `txData` is valid |
| txReady | output | 1 | Transmit buffer is empty |

## Verification
The assertions assume a well-formed bus. Each SCL level is held for many system clocks, so that synchronized edges on SCL and SDA never land in the same cycle. SDA changes only while SCL is low, except to form START and STOP. A START or STOP never occurs while the engine is pulling the line. The stimulus uses a controller model that holds every bus phase for eight system clocks and changes SDA only in the low phase of SCL. It forms START and STOP only while the data line is released. As a real controller would, it ends each read with a NACK, and it issues a STOP only after that NACK.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {PULL_KEEP, PULL_ACK, PULL_REL, PULL_DATA} pullOp_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_IGNORE
  } state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic sda;
  } busEvt_t;

  typedef struct packed {
    logic    sampleBit;
    logic    pubRx;
    logic    loadTx;
    logic    nextTx;
    pullOp_e pullOp;
  } strobe_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk or negedge rstN)
      if (!rstN) chain <= RST_VAL;
      else       chain <= d;
  end else begin : g_multi
    always_ff @(posedge clk or negedge rstN)
      if (!rstN) chain <= {STAGES{RST_VAL}};
      else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_tgt_dpath.sv
module i2c_tgt_dpath
  import i2c_tgt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h50,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  strobe_t           strb,
  output busEvt_t           evt,
  output logic              addrHit,
  output logic              rwBit,
  output logic              rxBusy,
  output logic              sdaPullEn,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  input  logic [BYTE_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady
);
  logic sclS, sdaS, sclQ, sdaQ;
  logic [BYTE_W-1:0] rxShift, txShift, txHold;
  logic txFull, txAccept, txNextMsb;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .d(sclIn), .q(sclS));
  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .d(sdaIn), .q(sdaS));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclS;
      sdaQ <= sdaS;
    end

  always_comb begin
    evt.rise  = sclS & ~sclQ;
    evt.fall  = ~sclS & sclQ;
    evt.start = sclS & sclQ & sdaQ & ~sdaS;
    evt.stop  = sclS & sclQ & ~sdaQ & sdaS;
    evt.sda   = sdaS;
  end

  // Receive shifter, MSB first
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) rxShift <= '0;
    else if (strb.sampleBit) rxShift <= {rxShift[BYTE_W-2:0], sdaS};

  assign addrHit = (rxShift[BYTE_W-1:1] == TARGET_ADDR);
  assign rwBit   = rxShift[0];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rxData  <= '0;
      rxValid <= 1'b0;
    end else if (strb.pubRx) begin
      rxData  <= rxShift;
      rxValid <= 1'b1;
    end else if (rxReady) begin
      rxValid <= 1'b0;
    end

  assign rxBusy = rxValid;

  // One-entry transmit buffer
  assign txReady  = ~txFull;
  assign txAccept = txValid & ~txFull;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      txHold <= '0;
      txFull <= 1'b0;
    end else if (txAccept) begin
      txHold <= txData;
      txFull <= 1'b1;
    end else if (strb.loadTx) begin
      txFull <= 1'b0;
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) txShift <= '1;
    else if (strb.loadTx) txShift <= txFull ? txHold : '1;
    else if (strb.nextTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};

  assign txNextMsb = strb.loadTx ? (txFull ? txHold[BYTE_W-1] : 1'b1)
                                 : txShift[BYTE_W-2];

  // Open-drain pull request
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) sdaPullEn <= 1'b0;
    else begin
      case (strb.pullOp)
        PULL_ACK:  sdaPullEn <= 1'b1;
        PULL_REL:  sdaPullEn <= 1'b0;
        PULL_DATA: sdaPullEn <= ~txNextMsb;
        default:   sdaPullEn <= sdaPullEn;
      endcase
    end

  a_r8_pull_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullEn) |-> !$past(sclS));

  a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData)));

  a_r10_tx_full: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  busEvt_t evt,
  input  logic    addrHit,
  input  logic    rwBit,
  input  logic    rxBusy,
  output strobe_t strb
);
  state_e state, stateNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic rwQ, rwNx, ackQ, ackNx;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      rwQ   <= 1'b0;
      ackQ  <= 1'b0;
    end else begin
      state <= stateNx;
      cnt   <= cntNx;
      rwQ   <= rwNx;
      ackQ  <= ackNx;
    end

  always_comb begin
    strb    = '0;
    stateNx = state;
    cntNx   = cnt;
    rwNx    = rwQ;
    ackNx   = ackQ;
    if (evt.start) begin
      stateNx     = ST_ADDR;
      cntNx       = '0;
      strb.pullOp = PULL_REL;
    end else if (evt.stop) begin
      stateNx     = ST_IDLE;
      cntNx       = '0;
      strb.pullOp = PULL_REL;
    end else begin
      case (state)
        ST_ADDR: begin
          if (evt.rise) begin
            strb.sampleBit = 1'b1;
            cntNx          = cnt + 1'b1;
          end else if (evt.fall && cnt == CNT_W'(BYTE_W)) begin
            rwNx = rwBit;
            if (addrHit) begin
              strb.pullOp = PULL_ACK;
              stateNx     = ST_ADDR_ACK;
            end else begin
              stateNx = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (evt.fall) begin
            cntNx = '0;
            if (rwQ) begin
              strb.loadTx = 1'b1;
              strb.pullOp = PULL_DATA;
              stateNx     = ST_RD;
            end else begin
              strb.pullOp = PULL_REL;
              stateNx     = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (evt.rise) begin
            strb.sampleBit = 1'b1;
            cntNx          = cnt + 1'b1;
          end else if (evt.fall && cnt == CNT_W'(BYTE_W)) begin
            if (!rxBusy) begin
              strb.pubRx  = 1'b1;
              strb.pullOp = PULL_ACK;
            end
            stateNx = ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (evt.fall) begin
            strb.pullOp = PULL_REL;
            cntNx       = '0;
            stateNx     = ST_WR;
          end
        end
        ST_RD: begin
          if (evt.rise) begin
            cntNx = cnt + 1'b1;
          end else if (evt.fall) begin
            if (cnt == CNT_W'(BYTE_W)) begin
              strb.pullOp = PULL_REL;
              stateNx     = ST_RD_ACK;
            end else begin
              strb.nextTx = 1'b1;
              strb.pullOp = PULL_DATA;
            end
          end
        end
        ST_RD_ACK: begin
          if (evt.rise) begin
            ackNx = ~evt.sda;
          end else if (evt.fall) begin
            cntNx = '0;
            if (ackQ) begin
              strb.loadTx = 1'b1;
              strb.pullOp = PULL_DATA;
              stateNx     = ST_RD;
            end else begin
              stateNx = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  a_r2_start_addr: assert property (@(posedge clk) disable iff (!rstN)
    evt.start |=> (state == ST_ADDR && cnt == '0));

  a_r3_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    evt.stop |=> (state == ST_IDLE));

  a_r5_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE || state == ST_IDLE) |->
      (strb.pullOp != PULL_ACK && strb.pullOp != PULL_DATA));

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(BYTE_W));
endmodule

// File: rtl/i2c_tgt_top.sv
module i2c_tgt_top
  import i2c_tgt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h50,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullEn,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  input  logic [BYTE_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady
);
  busEvt_t evt;
  strobe_t strb;
  logic addrHit, rwBit, rxBusy;

  i2c_tgt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .addrHit(addrHit),
    .rwBit(rwBit), .rxBusy(rxBusy), .strb(strb));

  i2c_tgt_dpath #(.TARGET_ADDR(TARGET_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .evt(evt), .addrHit(addrHit), .rwBit(rwBit), .rxBusy(rxBusy),
    .sdaPullEn(sdaPullEn), .rxData(rxData), .rxValid(rxValid),
    .rxReady(rxReady), .txData(txData), .txValid(txValid), .txReady(txReady));
endmodule

// File: tb/sim_i2c_tgt_top.sv
module sim_i2c_tgt_top;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclCtl = 1'b1, sdaCtl = 1'b1;
  logic rxReady = 1'b0, txValid = 1'b0;
  logic [7:0] txData = '0;
  logic sdaPullEn, rxValid, txReady;
  logic [7:0] rxData;
  logic sdaLine;

  int vectors = 0;
  int errs = 0;
  logic silent = 1'b0, sawPull = 1'b0;
  logic [7:0] rxExp[$];

  always #2 clk = ~clk;

  assign sdaLine = sdaCtl & ~sdaPullEn;

  i2c_tgt_top u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclCtl), .sdaIn(sdaLine),
    .sdaPullEn(sdaPullEn), .rxData(rxData), .rxValid(rxValid),
    .rxReady(rxReady), .txData(txData), .txValid(txValid), .txReady(txReady));

  always @(negedge clk) if (silent && sdaPullEn) sawPull = 1'b1;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaCtl = 1'b1; waitQ();
    sclCtl = 1'b1; waitQ();
    sdaCtl = 1'b0; waitQ();
    sclCtl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaCtl = 1'b0; waitQ();
    sclCtl = 1'b1; waitQ();
    sdaCtl = 1'b1; waitQ();
  endtask

  // One bit: drive in SCL low, sample mid-high, pull must hold while high (R8)
  task automatic clockBit(input logic b, output logic seen);
    logic p1;
    sdaCtl = b; waitQ();
    sclCtl = 1'b1; waitQ();
    seen = sdaLine;
    p1 = sdaPullEn;
    waitQ();
    check("R8 pull stable while SCL high", {7'd0, sdaPullEn}, {7'd0, p1});
    sclCtl = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, input logic expAck, input string req);
    logic seen;
    for (int i = 7; i >= 0; i--) clockBit(b[i], seen);
    clockBit(1'b1, seen);
    check({req, " ack"}, {7'd0, ~seen}, {7'd0, expAck});
  endtask

  task automatic readByte(input logic [7:0] exp, input logic ctlAck, input string req);
    logic seen;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, seen);
      got[i] = seen;
    end
    check({req, " read data"}, got, exp);
    clockBit(~ctlAck, seen);
  endtask

  task automatic offerTx(input logic [7:0] b);
    @(negedge clk);
    txData = b; txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
    check("R10 txReady low when full", {7'd0, txReady}, 8'd0);
  endtask

  task automatic consumeRx(input string req);
    logic [7:0] e;
    e = rxExp.pop_front();
    check({req, " rxValid"}, {7'd0, rxValid}, 8'd1);
    check({req, " rxData"}, rxData, e);
    @(negedge clk); rxReady = 1'b1;
    @(negedge clk); rxReady = 1'b0;
    check("R7 rxValid cleared by rxReady", {7'd0, rxValid}, 8'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin : stim
    logic seen;
    repeat (5) @(negedge clk);
    check("R1 pull after reset", {7'd0, sdaPullEn}, 8'd0);
    check("R1 rxValid after reset", {7'd0, rxValid}, 8'd0);
    check("R1 txReady after reset", {7'd0, txReady}, 8'd1);
    rstN = 1'b1;
    waitQ();

    // Write transfer with back-pressure (R4, R6, R7)
    busStart();
    writeByte({ADDR, 1'b0}, 1'b1, "R4 address write");
    writeByte(8'hA5, 1'b1, "R6 write byte");
    rxExp.push_back(8'hA5);
    writeByte(8'h3C, 1'b0, "R7 busy byte NACK");
    check("R7 rxData held", rxData, 8'hA5);
    consumeRx("R6");
    writeByte(8'h3C, 1'b1, "R6 second write byte");
    rxExp.push_back(8'h3C);
    consumeRx("R6");
    busStop();

    // Read transfer (R8, R9, R10)
    offerTx(8'h96);
    busStart();
    writeByte({ADDR, 1'b1}, 1'b1, "R4 address read");
    offerTx(8'h4B);
    readByte(8'h96, 1'b1, "R8 first");
    readByte(8'h4B, 1'b0, "R9 acked next");
    check("R9 released after NACK", {7'd0, sdaPullEn}, 8'd0);
    readByte(8'hFF, 1'b0, "R9 no drive after NACK");
    busStop();

    // Empty buffer read (R10)
    busStart();
    writeByte({ADDR, 1'b1}, 1'b1, "R4 address read");
    readByte(8'hFF, 1'b0, "R10 empty buffer");
    busStop();

    // Address mismatch (R5)
    sawPull = 1'b0; silent = 1'b1;
    busStart();
    writeByte({7'h51, 1'b0}, 1'b0, "R5 mismatch");
    writeByte(8'h00, 1'b0, "R5 data after mismatch");
    busStop();
    silent = 1'b0;
    check("R5 never pulled", {7'd0, sawPull}, 8'd0);
    check("R5 rxValid untouched", {7'd0, rxValid}, 8'd0);

    // START in mid-byte restarts address reception (R2)
    busStart();
    clockBit(1'b1, seen);
    clockBit(1'b0, seen);
    clockBit(1'b1, seen);
    busStart();
    writeByte({ADDR, 1'b0}, 1'b1, "R2 address after restart");
    writeByte(8'h77, 1'b1, "R2 write after restart");
    rxExp.push_back(8'h77);
    consumeRx("R2");
    busStop();

    // Clocks after STOP get no response (R3)
    sawPull = 1'b0; silent = 1'b1;
    sclCtl = 1'b0; waitQ();
    writeByte({ADDR, 1'b0}, 1'b0, "R3 clocks after STOP");
    sdaCtl = 1'b1; waitQ();
    sclCtl = 1'b1; waitQ();
    silent = 1'b0;
    check("R3 never pulled after STOP", {7'd0, sawPull}, 8'd0);
    check("R3 rxValid untouched", {7'd0, rxValid}, 8'd0);

    busStart();
    writeByte({ADDR, 1'b0}, 1'b1, "R3 new START answered");
    busStop();

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule